// File: doc/BRIEF.md
# Serial Row/Column Address Receiver

This block takes the row and column addresses of a sequential-access video memory as bit-serial words. Each address shares one serial data pin and one serial clock, and each has its own framing strobe. The block turns each word into parallel form and checks its length. The row word is range-checked and held. The column word is split into a column index and a transfer mode code.

When a column word is accepted, the block presents three fields together to the decoders and the transfer controller: the held row, the column index and the mode code. A single-cycle valid pulse marks them. What each mode does is decided downstream.

The serial inputs are treated as asynchronous to the system clock. They pass through a parameterised synchronizer before they are used. A word is framed by the high period of its strobe, and only rising serial-clock edges inside that period shift bits in.

Top module: `ser_addr_rx`

## Requirements
- R1: While reset is active and directly after it, `addr_vld`, `len_err` and `row_err` are low and `row_addr`, `col_addr` and `mode` are all zero; the held row starts at zero.
- R2: While `row_stb` is high, each rising edge of `sclk` shifts `sdat` into the row word, first bit = bit 7 (MSB first). When `row_stb` falls after exactly 8 bits, the held row is replaced by the word if it is in range.
- R3: The column word is shifted in the same way under `col_stb`. Its bits [7:6] form `mode` and its bits [5:0] form `col_addr`. When `col_stb` falls after exactly 8 bits, `row_addr`, `col_addr` and `mode` are updated.
- R4: `addr_vld` is high for exactly one clock for each accepted column word, in the same cycle the outputs take their new values. The outputs do not change in any other cycle.
- R5: `row_addr` carries the most recently accepted row word. Several column words after one row word all present that same row.
- R6: A row word of 212 or above pulses `row_err` for one clock and leaves the held row unchanged. `row_addr` therefore never exceeds 211.
- R7: A strobe that falls after any count other than 8 rising `sclk` edges (0, 7 or 9, for example) pulses `len_err` for one clock and discards the word. No `addr_vld` pulse follows and the held row is unchanged.
- R8: Rising `sclk` edges while both strobes are low change nothing: the next correctly framed word is received intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial address clock, sampled on rising edge |
| sdat | input | 1 | Serial address data bit, MSB first |
| row_stb | input | 1 | Frames a row word while high |
| col_stb | input | 1 | Frames a column word while high |
| row_addr | output | 8 | Latched row presented with the column |
| col_addr | output | 6 | Latched column index |
| mode | output | 2 | Latched transfer/refresh mode code |
| addr_vld | output | 1 | One-cycle pulse: new row/column/mode presented |
| len_err | output | 1 | One-cycle pulse: word framed with wrong bit count |
| row_err | output | 1 | One-cycle pulse: row word out of range |

## Verification
Some properties must hold on every cycle, and the bound assertions watch those. The valid pulse never lasts more than one clock. The presented row, column and mode hold still whenever no valid pulse is present. The presented row never reaches the out-of-range limit. All outputs are quiet under reset. The serial scenarios can only be checked against words the bench encodes itself. These cover MSB-first bit order, the split into mode and column, reuse of a held row across several columns, and discarding of short, long and empty frames. They also show that out-of-range rows are rejected and that stray serial clocks outside a frame are ignored.

// File: rtl/arx_pkg.sv
package arx_pkg;
   // channel indices of the two serial word receivers
   localparam int CH_ROW = 0;
   localparam int CH_COL = 1;
   localparam int N_CH   = 2;
endpackage

// File: rtl/arx_sync.sv
module arx_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stage [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage[i] <= '0;
            end else begin
               stage[0] <= d;
               for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
            end
         end
         assign q = stage[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/arx_deser.sv
module arx_deser #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb,
   input  logic              bit_rise,
   input  logic              bit_val,
   output logic [WORD_W-1:0] word,
   output logic              done,
   output logic              bad
);
   localparam int CNT_W = $clog2(WORD_W + 2);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

   logic [CNT_W-1:0] cnt;
   logic             stb_q;
   logic             stb_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word  <= '0;
         cnt   <= '0;
         stb_q <= 1'b0;
      end else begin
         stb_q <= stb;
         if (stb) begin
            if (bit_rise) begin
               word <= {word[WORD_W-2:0], bit_val};
               if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
            end
         end else begin
            cnt <= '0;
         end
      end
   end

   assign stb_fall = stb_q & ~stb;
   assign done     = stb_fall & (cnt == CNT_FULL);
   assign bad      = stb_fall & (cnt != CNT_FULL);
endmodule

// File: rtl/arx_hold.sv
module arx_hold #(
   parameter int WORD_W    = 8,
   parameter int COL_W     = 6,
   parameter int MODE_W    = 2,
   parameter int ROW_COUNT = 212
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              row_done,
   input  logic              row_bad,
   input  logic [WORD_W-1:0] row_word,
   input  logic              col_done,
   input  logic              col_bad,
   input  logic [WORD_W-1:0] col_word,
   output logic [WORD_W-1:0] row_addr,
   output logic [COL_W-1:0]  col_addr,
   output logic [MODE_W-1:0] mode,
   output logic              addr_vld,
   output logic              len_err,
   output logic              row_err
);
   localparam logic [WORD_W-1:0] ROW_LIM = WORD_W'(ROW_COUNT);

   logic [WORD_W-1:0] held_row;
   logic [WORD_W-1:0] row_next;
   logic              row_ok;

   always_comb begin
      row_ok   = row_done && (row_word < ROW_LIM);
      row_next = row_ok ? row_word : held_row;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_row <= '0;
         row_addr <= '0;
         col_addr <= '0;
         mode     <= '0;
         addr_vld <= 1'b0;
         len_err  <= 1'b0;
         row_err  <= 1'b0;
      end else begin
         held_row <= row_next;
         addr_vld <= col_done;
         len_err  <= row_bad | col_bad;
         row_err  <= row_done & ~row_ok;
         if (col_done) begin
            row_addr <= row_next;
            col_addr <= col_word[COL_W-1:0];
            mode     <= col_word[WORD_W-1:COL_W];
         end
      end
   end
endmodule

// File: rtl/ser_addr_rx.sv
module ser_addr_rx #(
   parameter int WORD_W      = 8,
   parameter int COL_W       = 6,
   parameter int MODE_W      = 2,
   parameter int ROW_COUNT   = 212,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              sdat,
   input  logic              row_stb,
   input  logic              col_stb,
   output logic [WORD_W-1:0] row_addr,
   output logic [COL_W-1:0]  col_addr,
   output logic [MODE_W-1:0] mode,
   output logic              addr_vld,
   output logic              len_err,
   output logic              row_err
);
   import arx_pkg::*;

   localparam int IN_W = 2 + N_CH;

   generate
      if (COL_W + MODE_W != WORD_W) begin : g_bad_split
         $error("column index and mode must fill the word");
      end
      if (ROW_COUNT < 1 || ROW_COUNT > (1 << WORD_W)) begin : g_bad_rows
         $error("row count does not fit the word");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("sync stage count must not be negative");
      end
   endgenerate

   logic [IN_W-1:0]   raw_in, syn_in;
   logic              sclk_s, sdat_s, sclk_q, sclk_rise;
   logic [N_CH-1:0]   stb_s, ch_done, ch_bad;
   logic [WORD_W-1:0] ch_word [N_CH];

   assign raw_in = {col_stb, row_stb, sdat, sclk};

   arx_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
   );

   assign sclk_s = syn_in[0];
   assign sdat_s = syn_in[1];
   assign stb_s  = syn_in[IN_W-1:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= sclk_s;
   end
   assign sclk_rise = sclk_s & ~sclk_q;

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         arx_deser #(.WORD_W(WORD_W)) u_deser (
            .clk(clk), .rst_n(rst_n), .stb(stb_s[c]),
            .bit_rise(sclk_rise), .bit_val(sdat_s),
            .word(ch_word[c]), .done(ch_done[c]), .bad(ch_bad[c])
         );
      end
   endgenerate

   arx_hold #(
      .WORD_W(WORD_W), .COL_W(COL_W), .MODE_W(MODE_W), .ROW_COUNT(ROW_COUNT)
   ) u_hold (
      .clk(clk), .rst_n(rst_n),
      .row_done(ch_done[CH_ROW]), .row_bad(ch_bad[CH_ROW]), .row_word(ch_word[CH_ROW]),
      .col_done(ch_done[CH_COL]), .col_bad(ch_bad[CH_COL]), .col_word(ch_word[CH_COL]),
      .row_addr(row_addr), .col_addr(col_addr), .mode(mode),
      .addr_vld(addr_vld), .len_err(len_err), .row_err(row_err)
   );
endmodule

// File: rtl/arx_chk.sv
module arx_chk #(
   parameter int WORD_W    = 8,
   parameter int COL_W     = 6,
   parameter int MODE_W    = 2,
   parameter int ROW_COUNT = 212
) (
   input logic              clk,
   input logic              rst_n,
   input logic [WORD_W-1:0] row_addr,
   input logic [COL_W-1:0]  col_addr,
   input logic [MODE_W-1:0] mode,
   input logic              addr_vld,
   input logic              len_err,
   input logic              row_err
);
   localparam logic [WORD_W-1:0] ROW_LIM = WORD_W'(ROW_COUNT);

   // R1
   always @(negedge clk) begin
      if (!rst_n) begin
         reset_quiet_chk: assert (!addr_vld && !len_err && !row_err &&
                                  row_addr == '0 && col_addr == '0 && mode == '0)
            else $error("outputs not quiet in reset");
      end
   end

   // R4
   vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_vld |=> !addr_vld);

   // R4
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_vld |-> ($stable(row_addr) && $stable(col_addr) && $stable(mode)));

   // R6
   row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_addr < ROW_LIM);
endmodule

bind ser_addr_rx arx_chk #(
   .WORD_W(WORD_W), .COL_W(COL_W), .MODE_W(MODE_W), .ROW_COUNT(ROW_COUNT)
) u_arx_chk (
   .clk(clk), .rst_n(rst_n), .row_addr(row_addr), .col_addr(col_addr),
   .mode(mode), .addr_vld(addr_vld), .len_err(len_err), .row_err(row_err)
);

// File: tb/test_ser_addr_rx.sv
module test_ser_addr_rx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0, sdat = 1'b0, row_stb = 1'b0, col_stb = 1'b0;
   logic [7:0] row_addr;
   logic [5:0] col_addr;
   logic [1:0] mode;
   logic       addr_vld, len_err, row_err;

   int n_run = 0, n_fail = 0;
   int vld_cnt = 0, len_cnt = 0, rerr_cnt = 0, dbl_cnt = 0;
   logic prev_vld = 1'b0;

   always #2 clk = ~clk;

   ser_addr_rx i_ser_addr_rx (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdat(sdat),
      .row_stb(row_stb), .col_stb(col_stb),
      .row_addr(row_addr), .col_addr(col_addr), .mode(mode),
      .addr_vld(addr_vld), .len_err(len_err), .row_err(row_err)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (addr_vld) begin
            vld_cnt++;
            if (prev_vld) dbl_cnt++;
         end
         if (len_err) len_cnt++;
         if (row_err) rerr_cnt++;
      end
      prev_vld = addr_vld;
   end

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic send_word(input bit is_col, input logic [7:0] v, input int nbits);
      @(negedge clk);
      if (is_col) col_stb = 1'b1; else row_stb = 1'b1;
      repeat (2) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         sdat = (i < 8) ? v[7-i] : 1'b0;
         repeat (2) @(negedge clk);
         sclk = 1'b1;
         repeat (3) @(negedge clk);
         sclk = 1'b0;
         @(negedge clk);
      end
      repeat (2) @(negedge clk);
      row_stb = 1'b0;
      col_stb = 1'b0;
      repeat (10) @(negedge clk);
   endtask

   task automatic expect_col(input string req, input logic [7:0] cw, input int exp_row);
      int v0 = vld_cnt;
      send_word(1'b1, cw, 8);
      check({req, " vld count"}, vld_cnt, v0 + 1);
      check({req, " row"}, row_addr, exp_row);
      check({req, " col"}, col_addr, cw[5:0]);
      check({req, " mode"}, mode, cw[7:6]);
   endtask

   task automatic t_reset;
      check("R1 vld", addr_vld, 0);
      check("R1 errs", {len_err, row_err}, 0);
      check("R1 fields", {row_addr, col_addr, mode}, 0);
   endtask

   task automatic t_basic;
      send_word(1'b0, 8'd5, 8);
      expect_col("R2 R3 basic", {2'b10, 6'd33}, 5);
   endtask

   task automatic t_patterns;
      send_word(1'b0, 8'd211, 8);
      expect_col("R3 max", {2'b11, 6'd63}, 211);
      send_word(1'b0, 8'd0, 8);
      expect_col("R3 zero", {2'b00, 6'd0}, 0);
      send_word(1'b0, 8'hA5, 8);
      expect_col("R2 msb first", {2'b01, 6'h2A}, 8'hA5);
   endtask

   task automatic t_reuse;
      send_word(1'b0, 8'd77, 8);
      expect_col("R5 first", {2'b01, 6'd1}, 77);
      expect_col("R5 second", {2'b10, 6'd50}, 77);
   endtask

   task automatic t_row_range;
      int r0 = rerr_cnt;
      send_word(1'b0, 8'd40, 8);
      send_word(1'b0, 8'd212, 8);
      check("R6 err at 212", rerr_cnt, r0 + 1);
      send_word(1'b0, 8'd255, 8);
      check("R6 err at 255", rerr_cnt, r0 + 2);
      expect_col("R6 row kept", {2'b00, 6'd9}, 40);
   endtask

   task automatic t_length;
      int l0 = len_cnt;
      int v0 = vld_cnt;
      send_word(1'b0, 8'd30, 8);
      send_word(1'b0, 8'd100, 7);
      check("R7 short row err", len_cnt, l0 + 1);
      send_word(1'b1, 8'h3F, 9);
      check("R7 long col err", len_cnt, l0 + 2);
      send_word(1'b1, 8'h00, 0);
      check("R7 empty col err", len_cnt, l0 + 3);
      check("R7 no vld", vld_cnt, v0);
      expect_col("R7 row kept", {2'b11, 6'd17}, 30);
   endtask

   task automatic t_stray;
      int l0 = len_cnt;
      int v0 = vld_cnt;
      for (int i = 0; i < 5; i++) begin
         sdat = i[0];
         repeat (2) @(negedge clk);
         sclk = 1'b1;
         repeat (3) @(negedge clk);
         sclk = 1'b0;
         @(negedge clk);
      end
      repeat (10) @(negedge clk);
      check("R8 no pulses", vld_cnt + len_cnt, v0 + l0);
      send_word(1'b0, 8'd150, 8);
      expect_col("R8 intact", {2'b10, 6'd21}, 150);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset;
      t_basic;
      t_patterns;
      t_reuse;
      t_row_range;
      t_length;
      t_stray;
      check("R4 single-cycle vld", dbl_cnt, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule